// File: doc/BRIEF.md
# Banked Debug Comparator Register Window

This block holds the programmable state of a three-channel bus-match debug unit and makes it visible to the CPU through a byte-wide register port. Three comparators share one 8-byte window. A small select register picks which comparator currently occupies the window.

Comparator A is the full-size channel. It has a control byte, a three-byte match address, a two-byte data compare value and a two-byte data mask. Comparators B and C have only the control byte and the address. The window bytes that a smaller comparator lacks read as zero and discard writes. The stored values are driven out in parallel to the comparison datapath.

A separate flag byte records which channels matched during a debug session. A match pulse from a channel sets that channel's flag only while the session is active. The flag then stays set, so software can inspect it after the session ends. Software cannot clear the flags. Only the arm strobe, which starts a new session, clears them. The flag byte is visible only when the select field holds its all-ones value.

Top module: `dbgw_window`

## Requirements
- R1: After reset, the select field, every comparator byte and every match flag are zero, so every readable offset returns 0x00 and every parallel output is zero.
- R2: Offset 0x20 is the window select register. Bits [1:0] are read/write and choose the bank: 0 selects comparator A, 1 selects B, 2 selects C and 3 selects the flag view. Bits [7:2] read as zero.
- R3: With bank 0, 1 or 2 selected, window offset 0x28 is that comparator's control byte. Offsets 0x29, 0x2A and 0x2B are address bits [23:16], [15:8] and [7:0]. A write changes only the selected comparator, and the stored bytes appear on its parallel outputs on the next cycle.
- R4: With comparator A selected, offsets 0x2C and 0x2D hold data compare bits [15:8] and [7:0]. Offsets 0x2E and 0x2F hold mask bits [15:8] and [7:0].
- R5: With comparator B or C selected, offsets 0x2C to 0x2F read as zero, and writes to them change no stored value.
- R6: With bank 3 selected, all of 0x28 to 0x2F read as zero, and writes to them change no comparator.
- R7: Offset 0x27 returns the match flags when the select field is 3. Bit 0 is channel A, bit 1 is B, bit 2 is C, and bits [7:3] are zero. With any other select value, offset 0x27 reads as zero.
- R8: Writes to offset 0x27 never change the flags.
- R9: A match pulse on a channel while the session is active sets that channel's flag on the next clock. A set flag stays set. A flag on one channel neither blocks nor alters the others.
- R10: Match pulses while the session is inactive set no flag.
- R11: An arm strobe clears all flags on the next clock. It takes priority over a match pulse in the same cycle.
- R12: Offsets outside 0x20 and 0x27 to 0x2F read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write enable for the addressed byte |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the addressed byte (combinational) |
| arm_i | input | 1 | Arm strobe; clears all match flags |
| session_active_i | input | 1 | High while a debug session is running |
| match_i | input | 3 | Per-channel match pulses, bit 0 = A |
| cmp_ctrl_o | output | 24 | Control bytes, channel n at [8n+7:8n] |
| cmp_addr_o | output | 72 | Match addresses, channel n at [24n+23:24n] |
| cmp_dval_o | output | 16 | Comparator A data compare value |
| cmp_dmask_o | output | 16 | Comparator A data mask |
| match_flags_o | output | 3 | Sticky match flags, bit 0 = A |

## Verification
The hardest situation to reach is an arm strobe and a match pulse in the same cycle, together with stale flags from an earlier session that must survive writes to the flag offset. The bench reaches it by driving every pair of match patterns across two pulses after an arm. It then issues arm and match together while flags are already set. Separately, it writes all 256 offsets under each bank and reads them back under every bank against an arithmetic model. This exposes any byte that leaks between comparators, or into the read-as-zero slots.

// File: rtl/dbgw_pkg.sv
package dbgw_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_BYTES = 3;
    localparam int DATA_BYTES = 2;
    localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;

    // byte slot inside the 8-byte window; order is fixed by the layout
    typedef enum logic [2:0] {
        SLOT_CTRL = 3'd0,
        SLOT_AH   = 3'd1,
        SLOT_AM   = 3'd2,
        SLOT_AL   = 3'd3,
        SLOT_DH   = 3'd4,
        SLOT_DL   = 3'd5,
        SLOT_MH   = 3'd6,
        SLOT_ML   = 3'd7
    } slot_e;

    typedef struct packed {
        logic [BYTE_W-1:0] ctrl;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dval;
        logic [DATA_W-1:0] dmask;
    } cmp_regs_t;

    function automatic logic [BYTE_W-1:0] slot_byte(cmp_regs_t r, slot_e s);
        logic [BYTE_W-1:0] b;
        case (s)
            SLOT_CTRL: b = r.ctrl;
            SLOT_AH:   b = r.addr[23:16];
            SLOT_AM:   b = r.addr[15:8];
            SLOT_AL:   b = r.addr[7:0];
            SLOT_DH:   b = r.dval[15:8];
            SLOT_DL:   b = r.dval[7:0];
            SLOT_MH:   b = r.dmask[15:8];
            default:   b = r.dmask[7:0];
        endcase
        return b;
    endfunction
endpackage

// File: rtl/dbgw_decode.sv
module dbgw_decode
    import dbgw_pkg::*;
#(
    parameter int              NUM_CH   = 3,
    parameter int              SEL_W    = 2,
    parameter int              REG_AW   = 8,
    parameter int              DATA_CH  = 0,
    parameter logic [REG_AW-1:0] WIN_BASE = 8'h28,
    parameter logic [REG_AW-1:0] FLAG_OFS = 8'h27,
    parameter logic [REG_AW-1:0] SEL_OFS  = 8'h20
) (
    input  logic [REG_AW-1:0] addr_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              sel_hit_o,
    output logic              flag_hit_o,
    output logic [NUM_CH-1:0] ch_hit_o,
    output slot_e             slot_o
);
    localparam int               SLOT_W    = 3;
    localparam logic [SEL_W-1:0] FLAG_BANK = '1;

    logic win_hit;

    always_comb begin
        win_hit    = (addr_i[REG_AW-1:SLOT_W] == WIN_BASE[REG_AW-1:SLOT_W]);
        slot_o     = slot_e'(addr_i[SLOT_W-1:0]);
        sel_hit_o  = (addr_i == SEL_OFS);
        flag_hit_o = (addr_i == FLAG_OFS) && (sel_i == FLAG_BANK);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            // a slot beyond the address bytes exists only on the data channel
            ch_hit_o[ch] = win_hit && (sel_i == SEL_W'(ch))
                        && ((ch == DATA_CH) || (slot_o <= SLOT_AL));
        end
    end
endmodule

// File: rtl/dbgw_cmp_bank.sv
module dbgw_cmp_bank
    import dbgw_pkg::*;
#(
    parameter bit HAS_DATA = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  slot_e             slot_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output cmp_regs_t         regs_o
);
    cmp_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            case (slot_i)
                SLOT_CTRL: r_d.ctrl          = wdata_i;
                SLOT_AH:   r_d.addr[23:16]   = wdata_i;
                SLOT_AM:   r_d.addr[15:8]    = wdata_i;
                SLOT_AL:   r_d.addr[7:0]     = wdata_i;
                SLOT_DH:   r_d.dval[15:8]    = wdata_i;
                SLOT_DL:   r_d.dval[7:0]     = wdata_i;
                SLOT_MH:   r_d.dmask[15:8]   = wdata_i;
                default:   r_d.dmask[7:0]    = wdata_i;
            endcase
        end
        if (!HAS_DATA) begin
            r_d.dval  = '0;
            r_d.dmask = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign regs_o = r_q;
endmodule

// File: rtl/dbgw_flags.sv
module dbgw_flags #(
    parameter int NUM_CH = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              arm_i,
    input  logic              active_i,
    input  logic [NUM_CH-1:0] match_i,
    output logic [NUM_CH-1:0] flags_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] flg;
    } flag_st_t;

    flag_st_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (arm_i)         f_d.flg = '0;
        else if (active_i) f_d.flg = f_q.flg | match_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) f_q <= '0;
        else         f_q <= f_d;
    end

    assign flags_o = f_q.flg;
endmodule

// File: rtl/dbgw_window.sv
module dbgw_window
    import dbgw_pkg::*;
#(
    parameter int                NUM_CH   = 3,
    parameter int                SEL_W    = 2,
    parameter int                DATA_CH  = 0,
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] WIN_BASE = 8'h28,
    parameter logic [REG_AW-1:0] FLAG_OFS = 8'h27,
    parameter logic [REG_AW-1:0] SEL_OFS  = 8'h20
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [REG_AW-1:0]        reg_addr_i,
    input  logic                     reg_wr_i,
    input  logic [BYTE_W-1:0]        reg_wdata_i,
    output logic [BYTE_W-1:0]        reg_rdata_o,
    input  logic                     arm_i,
    input  logic                     session_active_i,
    input  logic [NUM_CH-1:0]        match_i,
    output logic [NUM_CH*BYTE_W-1:0] cmp_ctrl_o,
    output logic [NUM_CH*ADDR_W-1:0] cmp_addr_o,
    output logic [DATA_W-1:0]        cmp_dval_o,
    output logic [DATA_W-1:0]        cmp_dmask_o,
    output logic [NUM_CH-1:0]        match_flags_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic              sel_hit, flag_hit;
    logic [NUM_CH-1:0] ch_hit;
    slot_e             slot;
    cmp_regs_t         regs [NUM_CH];
    logic [NUM_CH-1:0] flags;
    logic [SEL_W-1:0]  bank_sel;

    assign bank_sel = st_q.sel;

    dbgw_decode #(
        .NUM_CH  (NUM_CH),
        .SEL_W   (SEL_W),
        .REG_AW  (REG_AW),
        .DATA_CH (DATA_CH),
        .WIN_BASE(WIN_BASE),
        .FLAG_OFS(FLAG_OFS),
        .SEL_OFS (SEL_OFS)
    ) dec_i (
        .addr_i    (reg_addr_i),
        .sel_i     (st_q.sel),
        .sel_hit_o (sel_hit),
        .flag_hit_o(flag_hit),
        .ch_hit_o  (ch_hit),
        .slot_o    (slot)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dbgw_cmp_bank #(
            .HAS_DATA(ch == DATA_CH)
        ) bank_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .wr_i   (reg_wr_i && ch_hit[ch]),
            .slot_i (slot),
            .wdata_i(reg_wdata_i),
            .regs_o (regs[ch])
        );
        assign cmp_ctrl_o[ch*BYTE_W +: BYTE_W] = regs[ch].ctrl;
        assign cmp_addr_o[ch*ADDR_W +: ADDR_W] = regs[ch].addr;
    end

    assign cmp_dval_o  = regs[DATA_CH].dval;
    assign cmp_dmask_o = regs[DATA_CH].dmask;

    dbgw_flags #(
        .NUM_CH(NUM_CH)
    ) flags_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (arm_i),
        .active_i(session_active_i),
        .match_i (match_i),
        .flags_o (flags)
    );

    assign match_flags_o = flags;

    always_comb begin
        st_d = st_q;
        if (reg_wr_i && sel_hit) st_d.sel = reg_wdata_i[SEL_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel_hit)  reg_rdata_o = BYTE_W'(st_q.sel);
        if (flag_hit) reg_rdata_o = BYTE_W'(flags);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (ch_hit[ch]) reg_rdata_o = reg_rdata_o | slot_byte(regs[ch], slot);
        end
    end
endmodule

// File: rtl/dbgw_window_chk.sv
module dbgw_window_chk #(
    parameter int                NUM_CH   = 3,
    parameter int                SEL_W    = 2,
    parameter int                DATA_CH  = 0,
    parameter int                REG_AW   = 8,
    parameter logic [REG_AW-1:0] WIN_BASE = 8'h28,
    parameter logic [REG_AW-1:0] FLAG_OFS = 8'h27
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [REG_AW-1:0] reg_addr_i,
    input logic              reg_wr_i,
    input logic [7:0]        reg_rdata_o,
    input logic              arm_i,
    input logic              session_active_i,
    input logic [NUM_CH-1:0] match_i,
    input logic [NUM_CH-1:0] match_flags_o,
    input logic [15:0]       cmp_dval_o,
    input logic [15:0]       cmp_dmask_o,
    input logic [SEL_W-1:0]  bank_sel
);
    logic data_slot;
    assign data_slot = (reg_addr_i[REG_AW-1:3] == WIN_BASE[REG_AW-1:3]) && reg_addr_i[2];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // R9: a flag once set survives until an arm strobe
        p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_flags_o[ch] && !arm_i |=> match_flags_o[ch]);
        // R9: active match without arm sets the flag
        p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_i[ch] && session_active_i && !arm_i |=> match_flags_o[ch]);
        // R10: a clear flag stays clear without an active match
        p_flag_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !match_flags_o[ch] && !(match_i[ch] && session_active_i) |=> !match_flags_o[ch]);
    end

    // R11: arm clears every flag, regardless of matches
    p_arm_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> match_flags_o == '0);

    // R7: the flag offset is hidden unless the flag bank is selected
    p_flag_hidden_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_addr_i == FLAG_OFS) && (bank_sel != '1) |-> reg_rdata_o == 8'h00);

    // R5: data bytes are untouched by writes under a channel without data
    p_no_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_i && data_slot && (bank_sel != SEL_W'(DATA_CH))
        |=> $stable(cmp_dval_o) && $stable(cmp_dmask_o));

    // R8: writing the flag offset does not change flags
    p_flag_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_wr_i && (reg_addr_i == FLAG_OFS) && !arm_i && !session_active_i
        |=> $stable(match_flags_o));
endmodule

bind dbgw_window dbgw_window_chk #(
    .NUM_CH  (NUM_CH),
    .SEL_W   (SEL_W),
    .DATA_CH (DATA_CH),
    .REG_AW  (REG_AW),
    .WIN_BASE(WIN_BASE),
    .FLAG_OFS(FLAG_OFS)
) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .reg_addr_i      (reg_addr_i),
    .reg_wr_i        (reg_wr_i),
    .reg_rdata_o     (reg_rdata_o),
    .arm_i           (arm_i),
    .session_active_i(session_active_i),
    .match_i         (match_i),
    .match_flags_o   (match_flags_o),
    .cmp_dval_o      (cmp_dval_o),
    .cmp_dmask_o     (cmp_dmask_o),
    .bank_sel        (bank_sel)
);

// File: tb/dbgw_window_tb.sv
`timescale 1ns/1ps
module dbgw_window_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        arm = 1'b0;
    logic        act = 1'b0;
    logic [2:0]  match = '0;
    logic [23:0] cmp_ctrl;
    logic [71:0] cmp_addr;
    logic [15:0] cmp_dval, cmp_dmask;
    logic [2:0]  flags;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [7:0] m_ctrl [3];
    logic [7:0] m_addr [3][3];
    logic [7:0] m_dat  [4];
    logic [1:0] m_sel;
    logic [2:0] m_flags;

    always #2.5 clk = ~clk;

    dbgw_window dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .reg_addr_i      (reg_addr),
        .reg_wr_i        (reg_wr),
        .reg_wdata_i     (reg_wdata),
        .reg_rdata_o     (reg_rdata),
        .arm_i           (arm),
        .session_active_i(act),
        .match_i         (match),
        .cmp_ctrl_o      (cmp_ctrl),
        .cmp_addr_o      (cmp_addr),
        .cmp_dval_o      (cmp_dval),
        .cmp_dmask_o     (cmp_dmask),
        .match_flags_o   (flags)
    );

    task automatic check(input string req, input logic [127:0] act_v, input logic [127:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    function automatic logic [7:0] exp_read(input int a);
        int off;
        if (a == 'h20) return {6'b0, m_sel};
        if (a == 'h27) return (m_sel == 2'd3) ? {5'b0, m_flags} : 8'h00;
        if (a >= 'h28 && a <= 'h2F) begin
            off = a - 'h28;
            if (m_sel == 2'd3) return 8'h00;
            if (off == 0) return m_ctrl[m_sel];
            if (off <= 3) return m_addr[m_sel][off-1];
            if (m_sel != 2'd0) return 8'h00;
            return m_dat[off-4];
        end
        return 8'h00;
    endfunction

    function automatic string req_of(input int a);
        if (a == 'h20) return "R2";
        if (a == 'h27) return "R7";
        if (a >= 'h28 && a <= 'h2F) begin
            if (m_sel == 2'd3) return "R6";
            if (a >= 'h2C) return (m_sel == 2'd0) ? "R4" : "R5";
            return "R3";
        end
        return "R12";
    endfunction

    task automatic model_write(input int a, input logic [7:0] d);
        int off;
        if (a == 'h20) m_sel = d[1:0];
        else if (a >= 'h28 && a <= 'h2F && m_sel != 2'd3) begin
            off = a - 'h28;
            if (off == 0) m_ctrl[m_sel] = d;
            else if (off <= 3) m_addr[m_sel][off-1] = d;
            else if (m_sel == 2'd0) m_dat[off-4] = d;
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_addr = a[7:0];
        reg_wdata = d;
        reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic check_outs(input string tag);
        for (int ch = 0; ch < 3; ch++) begin
            check({tag, " R3 ctrl"}, 128'(cmp_ctrl[ch*8 +: 8]), 128'(m_ctrl[ch]));
            check({tag, " R3 addr"}, 128'(cmp_addr[ch*24 +: 24]),
                  128'({m_addr[ch][0], m_addr[ch][1], m_addr[ch][2]}));
        end
        check({tag, " R4 dval"},  128'(cmp_dval),  128'({m_dat[0], m_dat[1]}));
        check({tag, " R4 dmask"}, 128'(cmp_dmask), 128'({m_dat[2], m_dat[3]}));
    endtask

    task automatic check_all_reads(input string tag);
        for (int a = 0; a < 256; a++) begin
            reg_addr = a[7:0];
            #0.1;
            check({tag, " ", req_of(a)}, 128'(reg_rdata), 128'(exp_read(a)));
        end
    endtask

    task automatic pulse(input logic [2:0] m, input logic a_act, input logic a_arm);
        match = m;
        act = a_act;
        arm = a_arm;
        @(posedge clk);
        @(negedge clk);
        match = '0;
        act = 1'b0;
        arm = 1'b0;
        if (a_arm) m_flags = '0;
        else if (a_act) m_flags = m_flags | m;
    endtask

    task automatic check_flags(input string req);
        reg_addr = 8'h27;
        #0.1;
        check({req, " flag byte"}, 128'(reg_rdata), 128'({5'b0, m_flags}));
        check({req, " flag out"},  128'(flags),     128'(m_flags));
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_ctrl[c] = '0;
            for (int b = 0; b < 3; b++) m_addr[c][b] = '0;
        end
        for (int b = 0; b < 4; b++) m_dat[b] = '0;
        m_sel = '0;
        m_flags = '0;

        repeat (3) @(negedge clk);
        // R1: reset state at every offset and output
        check_all_reads("R1 reset");
        check_outs("R1 reset");
        check("R1 flags", 128'(flags), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // sweep: write every offset under each bank, read back under each bank
        for (int s = 0; s < 4; s++) begin
            wr('h20, 8'(s));
            for (int a = 0; a < 256; a++) begin
                if (a != 'h20) wr(a, 8'((s * 37 + a * 11) ^ 'hA5));
            end
            check_outs("sweep");
            for (int s2 = 0; s2 < 4; s2++) begin
                wr('h20, 8'(s2));
                check_all_reads("sweep");
            end
        end
        // R2: upper select bits are not stored
        wr('h20, 8'hFE);
        check_all_reads("R2 upper");

        // flag behaviour
        wr('h20, 8'h03);
        for (int p = 0; p < 8; p++) begin
            pulse(3'd0, 1'b0, 1'b1);
            pulse(3'(p), 1'b0, 1'b0);
            check_flags("R10 inactive");
            for (int q = 0; q < 8; q++) begin
                pulse(3'd0, 1'b0, 1'b1);
                check_flags("R11 arm");
                pulse(3'(p), 1'b1, 1'b0);
                check_flags("R9 first");
                pulse(3'(q), 1'b1, 1'b0);
                check_flags("R9 second");
            end
        end
        // R8: writes to the flag offset
        pulse(3'd0, 1'b0, 1'b1);
        pulse(3'b101, 1'b1, 1'b0);
        wr('h27, 8'h00);
        check_flags("R8 write zero");
        wr('h27, 8'hFF);
        check_flags("R8 write ones");
        // R11: arm beats a same-cycle match while flags are set
        pulse(3'b111, 1'b1, 1'b0);
        pulse(3'b111, 1'b1, 1'b1);
        check_flags("R11 priority");
        // R7: flags hidden under other banks
        pulse(3'b011, 1'b1, 1'b0);
        for (int s = 0; s < 3; s++) begin
            wr('h20, 8'(s));
            reg_addr = 8'h27;
            #0.1;
            check("R7 hidden", 128'(reg_rdata), 128'(0));
        end
        wr('h20, 8'h03);
        check_flags("R7 visible");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule